// File: doc/BRIEF.md
# Two-Stage Pipelined Instruction Cache

A read-only, direct-mapped instruction cache whose hit path is split across two fetch stages. In the first stage the incoming byte address is looked up: its index selects one line, and that line's valid bit and stored tag decide hit or miss. In the second stage the data array is read and the 32-bit instruction is returned. Because the two stages are registered apart, a new fetch can enter every cycle while hits keep coming. Each fetch completes two cycles after it is presented: the request cycle and the response cycle.

On a miss the request stays in the lookup stage for a fixed number of cycles, three by default. During that time the cache drives a line-refill request carrying the line-aligned address. The backing memory answers on a refill data bus with the whole line. In the last of those cycles the line is written, its tag is replaced and its valid bit is set. The request then moves to the data stage and its instruction is returned in the following cycle. A single-cycle invalidate input empties the whole cache.

The default geometry is eight lines of 16 bytes, so each line holds four instructions. Fetches are word aligned.

Top module: `icache_pipe`

## Requirements
- R1: After reset every line is empty: `rsp_valid`, `stall` and `fill_req` are low while no request is presented, and the first fetch to any line misses.
- R2: A fetch presented in cycle t that hits keeps `stall` low in cycle t. In cycle t+1 it raises `rsp_valid` with the instruction word selected by address bits [3:2] of the line.
- R3: Hits are fully pipelined. Fetches presented in consecutive cycles each produce a response in the following cycle, with no stall.
- R4: A missing fetch stays in the lookup stage for MISS_CYCLES (3) cycles. `stall` is high in the first two of those cycles and low in the third. `fill_req` is high in all three, with `fill_addr` equal to the fetch address with bits [3:0] cleared. The instruction appears in the cycle after the third. The requester holds its address while `stall` is high.
- R5: A refill writes the whole line, so a later fetch to any other word of that line hits.
- R6: Mapping is direct. The index is address bits [6:4] and the tag is bits [31:7]. A fetch with the same index but a different tag misses and replaces the line. A fetch of the old line then misses again.
- R7: A one-cycle pulse on `inv_all` clears every valid bit, so the next fetch to a previously resident line misses.
- R8: Address bits [1:0] have no effect. A fetch of address A+2 returns the same word as A, with the same hit behaviour.
- R9: `rsp_valid` is high only in the cycle after a request left the lookup stage. It is low during stall cycles and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_all | input | 1 | Clears every valid bit |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 32 | Fetch byte address, held while stall is high |
| stall | output | 1 | Request not taken this cycle; hold it |
| rsp_valid | output | 1 | Instruction returned this cycle |
| rsp_instr | output | 32 | Returned instruction |
| fill_req | output | 1 | Line refill in progress |
| fill_addr | output | 32 | Line-aligned refill address |
| fill_line | input | 128 | Refill line from backing memory, word 0 in the low bits |

## Verification
A wrong valid bit or stale tag shows up as a stall count of zero where two are expected, or the other way round. It is visible in the very cycle the fetch is presented. A wrong array write or word select shows up one cycle after the fetch leaves the lookup stage, as a mismatch on `rsp_instr`. The refill address can be checked in the first miss cycle. Conflict, invalidate and whole-line refill cases are each followed by a fetch whose stall count exposes whether the line state changed as required.

// File: rtl/icache_pkg.sv
// Shared constants and types for the two-stage instruction cache.
// Assumes 32-bit instructions, word aligned.
package icache_pkg;
    localparam int INSTR_W     = 32;
    localparam int INSTR_BYTES = INSTR_W / 8;
    typedef logic [INSTR_W-1:0] instr_t;
endpackage

// File: rtl/icache_tags.sv
// Tag and valid store of a direct-mapped cache.
// One valid bit and one tag register per line. The lookup compares the
// addressed line combinationally. Invalidate-all wins over a same-cycle write.
module icache_tags #(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_vec;
    logic [LINES-1:0] match_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             vld_q;
        logic [TAG_W-1:0] tag_q;

        // Valid bit: cleared by reset or invalidate, set by a refill of this line.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld_q <= 1'b0;
            else if (inv_all)
                vld_q <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(g))
                vld_q <= 1'b1;
        end

        // Tag register: loaded on a refill of this line.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g))
                tag_q <= wr_tag;
        end

        assign valid_vec[g] = vld_q;
        assign match_vec[g] = vld_q && (tag_q == lk_tag);
    end

    assign lk_hit = match_vec[lk_idx];

    // R7: an invalidate leaves no line valid.
    p_inv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_vec == '0));

    // R5: a refill leaves its line valid.
    p_fill_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inv_all) |=> valid_vec[$past(wr_idx)]);
endmodule

// File: rtl/icache_data.sv
// Data array of the cache: a whole line is written at once and
// one instruction word is read combinationally by line index and word select.
module icache_data
    import icache_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int IDX_W  = 3,
    parameter int WSEL_W = 2,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output instr_t            rd_data
);
    instr_t mem_q [LINES][WORDS];

    // Line write: every word of the addressed line is replaced.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int w = 0; w < WORDS; w++)
                mem_q[wr_idx][w] <= wr_line[w*INSTR_W +: INSTR_W];
        end
    end

    assign rd_data = mem_q[rd_idx][rd_word];
endmodule

// File: rtl/icache_miss_ctl.sv
// Miss sequencer: counts the cycles a missing request spends in the lookup
// stage. Stall is raised for all but the last of MISS_CYCLES cycles. In the
// last cycle the refill is committed. Assumes the request is held while stalled.
module icache_miss_ctl #(
    parameter int MISS_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lookup_miss,
    output logic stall,
    output logic fill_last
);
    localparam int CNT_W = (MISS_CYCLES > 2) ? $clog2(MISS_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Cycle counter of the current miss; restarts when no miss is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (lookup_miss && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    assign fill_last = lookup_miss && (cnt_q == LAST);
    assign stall     = lookup_miss && (cnt_q != LAST);

    // R4: the counter never passes the last miss cycle.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R4: a stalled miss is still missing in the next cycle.
    p_stall_continues_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> lookup_miss);
endmodule

// File: rtl/icache_pipe.sv
// Two-stage pipelined, direct-mapped, read-only instruction cache.
// Stage 1 checks the tag of req_addr. Stage 2 reads the data array
// for the request registered at the end of stage 1. A miss holds the request
// in stage 1 for MISS_CYCLES cycles while fill_line is taken from memory.
// Assumes the requester holds req_valid/req_addr while stall is high and that
// fill_line reflects fill_addr while fill_req is high.
module icache_pipe
    import icache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINES       = 8,
    parameter int LINE_BYTES  = 16,
    parameter int MISS_CYCLES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inv_all,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    stall,
    output logic                    rsp_valid,
    output logic [INSTR_W-1:0]      rsp_instr,
    output logic                    fill_req,
    output logic [ADDR_W-1:0]       fill_addr,
    input  logic [LINE_BYTES*8-1:0] fill_line
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WORDS  = LINE_BYTES / INSTR_BYTES;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BYTE_W = $clog2(INSTR_BYTES);

    logic [IDX_W-1:0]  s1_idx;
    logic [TAG_W-1:0]  s1_tag;
    logic [WSEL_W-1:0] s1_word;
    logic              s1_hit;
    logic              lookup_miss;
    logic              fill_last;
    logic              advance;
    logic              unused_addr_lo;

    logic              s2_valid_q;
    logic [IDX_W-1:0]  s2_idx_q;
    logic [WSEL_W-1:0] s2_word_q;
    instr_t            s2_data;

    assign s1_idx         = req_addr[OFF_W +: IDX_W];
    assign s1_tag         = req_addr[ADDR_W-1 -: TAG_W];
    assign s1_word        = req_addr[BYTE_W +: WSEL_W];
    assign unused_addr_lo = ^req_addr[BYTE_W-1:0];

    icache_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .inv_all(inv_all),
        .lk_idx (s1_idx),
        .lk_tag (s1_tag),
        .lk_hit (s1_hit),
        .wr_en  (fill_last),
        .wr_idx (s1_idx),
        .wr_tag (s1_tag)
    );

    assign lookup_miss = req_valid && !s1_hit;

    icache_miss_ctl #(.MISS_CYCLES(MISS_CYCLES)) u_miss (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_miss(lookup_miss),
        .stall      (stall),
        .fill_last  (fill_last)
    );

    assign advance   = req_valid && (s1_hit || fill_last);
    assign fill_req  = lookup_miss;
    assign fill_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // Stage register between lookup and data read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s2_valid_q <= 1'b0;
        else
            s2_valid_q <= advance;
    end

    // Line index and word select carried into the data stage.
    always_ff @(posedge clk) begin
        if (advance) begin
            s2_idx_q  <= s1_idx;
            s2_word_q <= s1_word;
        end
    end

    icache_data #(
        .LINES(LINES), .WORDS(WORDS), .IDX_W(IDX_W),
        .WSEL_W(WSEL_W), .LINE_W(LINE_W)
    ) u_data (
        .clk    (clk),
        .wr_en  (fill_last),
        .wr_idx (s1_idx),
        .wr_line(fill_line),
        .rd_idx (s2_idx_q),
        .rd_word(s2_word_q),
        .rd_data(s2_data)
    );

    assign rsp_valid = s2_valid_q;
    assign rsp_instr = s2_valid_q ? s2_data : '0;

    // R4: the requester keeps its address while stalled.
    p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(req_addr));

    // R9: a response always follows a presented request.
    p_rsp_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R9: a stalled cycle produces no response in the next cycle.
    p_no_rsp_after_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !rsp_valid);
endmodule

// File: tb/icache_pipe_test.sv
`timescale 1ns/1ps
module icache_pipe_test;
    localparam int MISS = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         inv_all = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         stall;
    logic         rsp_valid;
    logic [31:0]  rsp_instr;
    logic         fill_req;
    logic [31:0]  fill_addr;
    logic [127:0] fill_line;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    icache_pipe uut (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .req_valid(req_valid), .req_addr(req_addr),
        .stall(stall), .rsp_valid(rsp_valid), .rsp_instr(rsp_instr),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_line(fill_line)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h0001_0003) ^ 32'hC3C3_0000;
    endfunction

    // Backing memory model: answers the refill address combinationally.
    always_comb begin
        for (int w = 0; w < 4; w++)
            fill_line[w*32 +: 32] = mem_word(fill_addr + 32'(w*4));
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One fetch; expects the given number of stall cycles, then the word.
    task automatic fetch(input logic [31:0] a, input int exp_stalls, input string req);
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        if (exp_stalls > 0) begin
            chk(fill_req == 1'b1, {req, " fill_req"}, 32'(fill_req), 1);
            chk(fill_addr == {a[31:4], 4'h0}, {req, " fill_addr"}, fill_addr, {a[31:4], 4'h0});
        end
        while (stall && n < 10) begin
            chk(rsp_valid == 1'b0, {req, " R9 rsp during stall"}, 32'(rsp_valid), 0);
            n++;
            @(negedge clk);
            #1;
        end
        chk(n == exp_stalls, {req, " stall cycles"}, 32'(n), 32'(exp_stalls));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(rsp_valid == 1'b1, {req, " rsp_valid"}, 32'(rsp_valid), 1);
        chk(rsp_instr == mem_word(a), {req, " rsp_instr"}, rsp_instr, mem_word(a));
    endtask

    task automatic t_reset();
        #1;
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 0);
        chk(stall == 1'b0, "R1 reset stall", 32'(stall), 0);
        chk(fill_req == 1'b0, "R1 reset fill_req", 32'(fill_req), 0);
    endtask

    task automatic t_cold_miss();
        fetch(32'h0000_0104, MISS - 1, "R1 R4 cold miss");
        @(negedge clk); #1;
        chk(rsp_valid == 1'b0, "R9 idle rsp_valid", 32'(rsp_valid), 0);
    endtask

    task automatic t_whole_line();
        fetch(32'h0000_0100, 0, "R5 word0 hit");
        fetch(32'h0000_0108, 0, "R5 word2 hit");
        fetch(32'h0000_010C, 0, "R2 R5 word3 hit");
    endtask

    task automatic t_stream();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = 32'h0000_0100 + 32'(k*4);
            #1;
            chk(stall == 1'b0, "R3 stream stall", 32'(stall), 0);
            if (k > 0)
                chk(rsp_valid && rsp_instr == mem_word(32'h0000_0100 + 32'((k-1)*4)),
                    "R3 stream rsp", rsp_instr, mem_word(32'h0000_0100 + 32'((k-1)*4)));
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(rsp_valid && rsp_instr == mem_word(32'h0000_010C), "R3 stream last",
            rsp_instr, mem_word(32'h0000_010C));
        @(negedge clk); #1;
        chk(rsp_valid == 1'b0, "R9 after stream", 32'(rsp_valid), 0);
    endtask

    task automatic t_low_bits();
        fetch(32'h0000_010A, 0, "R8 low bits ignored");
    endtask

    task automatic t_conflict();
        fetch(32'h0000_0184, MISS - 1, "R6 conflict miss");
        fetch(32'h0000_0188, 0, "R6 new line hit");
        fetch(32'h0000_0104, MISS - 1, "R6 old line evicted");
        fetch(32'h0000_0114, MISS - 1, "R1 other index cold");
        fetch(32'h0000_0100, 0, "R6 neighbour index kept");
    endtask

    task automatic t_invalidate();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        fetch(32'h0000_0104, MISS - 1, "R7 miss after invalidate");
        fetch(32'h0000_0118, MISS - 1, "R7 second line miss");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_miss();
        t_whole_line();
        t_stream();
        t_low_bits();
        t_conflict();
        t_invalidate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule